// File: doc/BRIEF.md
# Slot-Aligned DRAM Read Backend

This block sits between a four-thread interleaved pipeline and a DRAM command bus. Each hardware thread owns one bank and one single-entry request buffer. A global slot counter rotates through the thread ids, one per cycle. In a slot, only the bank of the matching thread may place a command on the shared bus: first a row-open (RAS) command, and one full rotation later a column-read (CAS) command. If the owning bank has nothing to send, the slot stays empty. No other bank may use it.

The read data comes back on the data bus a fixed number of cycles after the RAS command. That delay is 10 + BL/2, where BL is the burst length. The block captures the word at that moment. It then holds the word until the slot counter next reaches the requesting thread's id, which stands for that thread's write-back stage, and presents it there for one cycle.

Every read therefore has a latency that can be composed from three parts. The first is the wait in the request buffer until the thread's slot comes round. The second is the fixed DRAM delay. The third is the wait for the write-back slot. None of the three depends on traffic from other threads.

Top module: `slot_aligned_read_backend`

## Requirements
- R1: While reset is held, and in the first cycle after reset, every `req_ready` bit is 1, `cmd_valid` is 0 and every `rsp_valid` bit is 0.
- R2: Slots are counted from 0 in the first cycle after reset is released. The slot of cycle n is n mod NTHR. Every command on the bus carries `cmd_bank` equal to the slot of the cycle it appears in.
- R3: A bank with no command due leaves its slot empty, with `cmd_valid` 0, even when other banks hold pending work.
- R4: A request is accepted in cycle a when `req_valid[t]` and `req_ready[t]` are both 1. Its RAS command appears in the first cycle after a whose slot is t, with `cmd_cas` = 0 and `cmd_addr` carrying the row. The row is the upper ROW_W bits of `req_addr[t*ADDR_W +: ADDR_W]`, zero-extended.
- R5: The CAS command follows exactly NTHR cycles after the RAS command, with `cmd_cas` = 1 and `cmd_addr` carrying the column, which is the lower COL_W bits of the address.
- R6: The word returned is the value of `dram_rdata` in the cycle exactly 10 + BL/2 cycles after the RAS cycle.
- R7: `rsp_valid[t]` is high only in a cycle whose slot is t, for exactly one cycle per read. It rises in the first such cycle after the capture cycle, with `rsp_data` holding the captured word. At most one `rsp_valid` bit is high at a time.
- R8: The response cycle minus the accept cycle equals BEL + (10 + BL/2) + TAL. BEL is the RAS cycle minus the accept cycle, from 1 to NTHR. TAL is the response cycle minus the capture cycle, from 1 to NTHR.
- R9: A bank holds one read at a time. `req_ready[t]` is 0 from the cycle after acceptance through the response cycle. A request offered while it is 0 is ignored and changes neither commands nor data.
- R10: The latency of a thread's read depends only on the slot phase of its accept cycle. It is the same whether the other threads are idle or fully loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NTHR | Per-thread read request strobe |
| req_addr | input | NTHR*(ROW_W+COL_W) | Per-thread address, row in the upper bits and column in the lower bits |
| req_ready | output | NTHR | Per-thread request buffer free |
| dram_rdata | input | DATA_W | Read data bus from the DRAM |
| cmd_valid | output | 1 | Command present on the bus this cycle |
| cmd_cas | output | 1 | 0 = RAS (row open), 1 = CAS (column read) |
| cmd_bank | output | $clog2(NTHR) | Bank that owns the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column address |
| rsp_valid | output | NTHR | One-cycle return strobe, one bit per thread |
| rsp_data | output | DATA_W | Returned read word |

## Verification
The bench first offers sparse requests. Each thread's accept cycle lands on every slot phase, so every backend wait from 1 to NTHR and every alignment wait is seen, which separates a wrong RAS slot from a wrong return slot. It then holds all request lines high while the addresses change every cycle. This saturates the bus and shows both that requests offered to a busy buffer are ignored and that loaded latencies match the sparse ones for each phase. A single-thread phase leaves three slots in four empty, which exposes any bank that takes another bank's slot. The DRAM data bus carries a distinct word in every cycle, so capturing one cycle early or late returns the wrong word.

// File: rtl/slot_read_pkg.sv
package slot_read_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PEND = 3'd1,
        ST_RASD = 3'd2,
        ST_WAIT = 3'd3,
        ST_HOLD = 3'd4
    } bank_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slot_rotator.sv
module slot_rotator #(
    parameter int unsigned NTHR  = 4,
    parameter int unsigned TID_W = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] slot_q
);

    logic [TID_W-1:0] slot_d;

    always_comb begin
        if (slot_q == TID_W'(NTHR - 1)) begin
            slot_d = '0;
        end else begin
            slot_d = slot_q + TID_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // R2: the rotation advances by one each cycle and wraps after the last thread
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != TID_W'(NTHR - 1)) |=> (slot_q == $past(slot_q) + TID_W'(1)));

    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == TID_W'(NTHR - 1)) |=> (slot_q == '0));

endmodule

// File: rtl/bank_read_ctrl.sv
module bank_read_ctrl
    import slot_read_pkg::*;
#(
    parameter int unsigned ID       = 0,
    parameter int unsigned NTHR     = 4,
    parameter int unsigned TID_W    = $clog2(NTHR),
    parameter int unsigned ROW_W    = 14,
    parameter int unsigned COL_W    = 10,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RD_DELAY = 14,
    parameter int unsigned CNT_W    = $clog2(RD_DELAY + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TID_W-1:0]       slot_i,
    input  logic                   req_valid_i,
    input  logic [ROW_W+COL_W-1:0] req_addr_i,
    output logic                   req_ready_o,
    output logic                   ras_o,
    output logic                   cas_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [COL_W-1:0]       col_o,
    input  logic [DATA_W-1:0]      rdata_i,
    output logic                   rsp_valid_o,
    output logic [DATA_W-1:0]      rsp_data_o
);

    typedef struct packed {
        bank_state_e       st;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] data;
    } bank_reg_t;

    bank_reg_t bank_d, bank_q;
    logic      my_slot;

    assign my_slot = (slot_i == TID_W'(ID));

    always_comb begin
        bank_d = bank_q;
        unique case (bank_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    bank_d.row = req_addr_i[ROW_W+COL_W-1:COL_W];
                    bank_d.col = req_addr_i[COL_W-1:0];
                    bank_d.st  = ST_PEND;
                end
            end
            ST_PEND: begin
                if (my_slot) begin
                    bank_d.cnt = CNT_W'(RD_DELAY - 1);
                    bank_d.st  = ST_RASD;
                end
            end
            ST_RASD: begin
                bank_d.cnt = bank_q.cnt - CNT_W'(1);
                if (my_slot) begin
                    bank_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (bank_q.cnt == '0) begin
                    bank_d.data = rdata_i;
                    bank_d.st   = ST_HOLD;
                end else begin
                    bank_d.cnt = bank_q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (my_slot) begin
                    bank_d.st = ST_IDLE;
                end
            end
            default: bank_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '{st: ST_IDLE, row: '0, col: '0, cnt: '0, data: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign req_ready_o = (bank_q.st == ST_IDLE);
    assign ras_o       = my_slot && (bank_q.st == ST_PEND);
    assign cas_o       = my_slot && (bank_q.st == ST_RASD);
    assign row_o       = bank_q.row;
    assign col_o       = bank_q.col;
    assign rsp_valid_o = my_slot && (bank_q.st == ST_HOLD);
    assign rsp_data_o  = rsp_valid_o ? bank_q.data : '0;

    // R9: an accepted request closes the buffer in the following cycle
    assert_accept_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R6: the read-delay counter starts from the full delay right after RAS
    assert_delay_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ras_o |=> (bank_q.cnt == CNT_W'(RD_DELAY - 1)));

    // R5: the CAS slot is reached before the data delay runs out
    assert_cas_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.st == ST_RASD) |-> (bank_q.cnt != '0));

    // R7: the return strobe lasts one cycle and frees the buffer
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

endmodule

// File: rtl/slot_bus_mux.sv
module slot_bus_mux #(
    parameter int unsigned NTHR   = 4,
    parameter int unsigned TID_W  = $clog2(NTHR),
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned CMD_AW = 14,
    parameter int unsigned DATA_W = 32
) (
    input  logic [NTHR-1:0]        ras_i,
    input  logic [NTHR-1:0]        cas_i,
    input  logic [NTHR*ROW_W-1:0]  row_i,
    input  logic [NTHR*COL_W-1:0]  col_i,
    input  logic [NTHR*DATA_W-1:0] rsp_data_i,
    output logic                   cmd_valid_o,
    output logic                   cmd_cas_o,
    output logic [TID_W-1:0]       cmd_bank_o,
    output logic [CMD_AW-1:0]      cmd_addr_o,
    output logic [DATA_W-1:0]      rsp_data_o
);

    always_comb begin
        cmd_valid_o = 1'b0;
        cmd_cas_o   = 1'b0;
        cmd_bank_o  = '0;
        cmd_addr_o  = '0;
        rsp_data_o  = '0;
        for (int b = 0; b < int'(NTHR); b++) begin
            if (ras_i[b]) begin
                cmd_valid_o = 1'b1;
                cmd_cas_o   = 1'b0;
                cmd_bank_o  = TID_W'(b);
                cmd_addr_o  = CMD_AW'(row_i[b*ROW_W +: ROW_W]);
            end
            if (cas_i[b]) begin
                cmd_valid_o = 1'b1;
                cmd_cas_o   = 1'b1;
                cmd_bank_o  = TID_W'(b);
                cmd_addr_o  = CMD_AW'(col_i[b*COL_W +: COL_W]);
            end
            rsp_data_o = rsp_data_o | rsp_data_i[b*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/slot_aligned_read_backend.sv
module slot_aligned_read_backend
    import slot_read_pkg::*;
#(
    parameter int unsigned NTHR   = 4,
    parameter int unsigned BL     = 8,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned TID_W    = $clog2(NTHR),
    localparam int unsigned ADDR_W   = ROW_W + COL_W,
    localparam int unsigned CMD_AW   = max_of(ROW_W, COL_W),
    localparam int unsigned RD_DELAY = 10 + BL / 2,
    localparam int unsigned CNT_W    = $clog2(RD_DELAY + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTHR-1:0]        req_valid,
    input  logic [NTHR*ADDR_W-1:0] req_addr,
    output logic [NTHR-1:0]        req_ready,
    input  logic [DATA_W-1:0]      dram_rdata,
    output logic                   cmd_valid,
    output logic                   cmd_cas,
    output logic [TID_W-1:0]       cmd_bank,
    output logic [CMD_AW-1:0]      cmd_addr,
    output logic [NTHR-1:0]        rsp_valid,
    output logic [DATA_W-1:0]      rsp_data
);

    logic [TID_W-1:0]       slot_q;
    logic [NTHR-1:0]        ras_v;
    logic [NTHR-1:0]        cas_v;
    logic [NTHR*ROW_W-1:0]  row_v;
    logic [NTHR*COL_W-1:0]  col_v;
    logic [NTHR*DATA_W-1:0] rdat_v;

    slot_rotator #(
        .NTHR (NTHR),
        .TID_W(TID_W)
    ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .slot_q(slot_q)
    );

    for (genvar g = 0; g < int'(NTHR); g++) begin : g_bank
        bank_read_ctrl #(
            .ID      (g),
            .NTHR    (NTHR),
            .TID_W   (TID_W),
            .ROW_W   (ROW_W),
            .COL_W   (COL_W),
            .DATA_W  (DATA_W),
            .RD_DELAY(RD_DELAY),
            .CNT_W   (CNT_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_i     (slot_q),
            .req_valid_i(req_valid[g]),
            .req_addr_i (req_addr[g*ADDR_W +: ADDR_W]),
            .req_ready_o(req_ready[g]),
            .ras_o      (ras_v[g]),
            .cas_o      (cas_v[g]),
            .row_o      (row_v[g*ROW_W +: ROW_W]),
            .col_o      (col_v[g*COL_W +: COL_W]),
            .rdata_i    (dram_rdata),
            .rsp_valid_o(rsp_valid[g]),
            .rsp_data_o (rdat_v[g*DATA_W +: DATA_W])
        );
    end

    slot_bus_mux #(
        .NTHR  (NTHR),
        .TID_W (TID_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .CMD_AW(CMD_AW),
        .DATA_W(DATA_W)
    ) u_mux (
        .ras_i      (ras_v),
        .cas_i      (cas_v),
        .row_i      (row_v),
        .col_i      (col_v),
        .rsp_data_i (rdat_v),
        .cmd_valid_o(cmd_valid),
        .cmd_cas_o  (cmd_cas),
        .cmd_bank_o (cmd_bank),
        .cmd_addr_o (cmd_addr),
        .rsp_data_o (rsp_data)
    );

    // R2: the bus owner is always the bank of the current slot
    assert_bus_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_bank == slot_q));

    // R3: no two banks drive the command bus together
    assert_single_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ras_v | cas_v));

    // R7: at most one thread receives data per cycle
    assert_one_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

endmodule

// File: tb/slot_aligned_read_backend_test.sv
module slot_aligned_read_backend_test;

    localparam int NT    = 4;
    localparam int BLEN  = 8;
    localparam int RW    = 14;
    localparam int CW    = 10;
    localparam int DW    = 32;
    localparam int AW    = RW + CW;
    localparam int TW    = 2;
    localparam int CAW   = 14;
    localparam int DLY   = 10 + BLEN / 2;
    localparam int NCYC  = 900;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NT-1:0]    req_valid = '0;
    logic [NT*AW-1:0] req_addr = '0;
    logic [NT-1:0]    req_ready;
    logic [DW-1:0]    dram_rdata = '0;
    logic             cmd_valid;
    logic             cmd_cas;
    logic [TW-1:0]    cmd_bank;
    logic [CAW-1:0]   cmd_addr;
    logic [NT-1:0]    rsp_valid;
    logic [DW-1:0]    rsp_data;

    slot_aligned_read_backend uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .dram_rdata(dram_rdata),
        .cmd_valid (cmd_valid),
        .cmd_cas   (cmd_cas),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    always #10 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    bit     done   = 1'b0;
    longint cyc    = 0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // reference model state, one entry per thread
    bit          busy [NT];
    longint      acc  [NT];
    longint      ras  [NT];
    longint      rr   [NT];
    logic [RW-1:0] mrow [NT];
    logic [CW-1:0] mcol [NT];
    longint      lat_tab [NT][NT];

    function automatic logic [DW-1:0] dfun(input longint n);
        return (DW'(n) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [AW-1:0] afun(input longint n, input int t);
        return AW'(n * 40503 + t * 977 + 12345);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NT-1:0] exp_rdy;
        for (int t = 0; t < NT; t++) begin
            busy[t] = 1'b0;
            for (int p = 0; p < NT; p++) lat_tab[t][p] = -1;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == '1, "R1 req_ready in reset", req_ready, 15);
        chk(cmd_valid == 1'b0, "R1 cmd_valid in reset", cmd_valid, 0);
        chk(rsp_valid == '0, "R1 rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NCYC; i++) begin
            longint n;
            int     s;
            bit     ev;
            bit     ecas;
            logic [CAW-1:0] eaddr;
            @(negedge clk);
            n = cyc;
            s = int'(n % NT);

            if (i == 0) begin
                chk(req_ready == '1, "R1 req_ready after reset", req_ready, 15);
                chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", cmd_valid, 0);
            end

            for (int t = 0; t < NT; t++) exp_rdy[t] = !busy[t];
            chk(req_ready == exp_rdy, "R9 req_ready", req_ready, exp_rdy);

            // command bus expectation
            ev = 1'b0; ecas = 1'b0; eaddr = '0;
            if (busy[s] && n == ras[s]) begin
                ev = 1'b1; ecas = 1'b0; eaddr = CAW'(mrow[s]);
            end else if (busy[s] && n == ras[s] + NT) begin
                ev = 1'b1; ecas = 1'b1; eaddr = CAW'(mcol[s]);
            end
            chk(cmd_valid == ev, ev ? "R4 cmd_valid" : "R3 idle slot", cmd_valid, ev);
            if (ev && cmd_valid) begin
                chk(cmd_bank == TW'(s), "R2 cmd_bank", cmd_bank, s);
                chk(cmd_cas == ecas, ecas ? "R5 cmd_cas" : "R4 cmd_cas", cmd_cas, ecas);
                chk(cmd_addr == eaddr, ecas ? "R5 column" : "R4 row", cmd_addr, eaddr);
            end

            // return path expectation
            for (int t = 0; t < NT; t++) begin
                bit er;
                er = busy[t] && (n == rr[t]);
                chk(rsp_valid[t] == er, "R7 rsp_valid", rsp_valid[t], er);
                if (er && rsp_valid[t]) begin
                    longint meas, bel, tal;
                    int     ph;
                    chk(rsp_data == dfun(ras[t] + DLY), "R6 captured word",
                        rsp_data, dfun(ras[t] + DLY));
                    meas = n - acc[t];
                    bel  = ras[t] - acc[t];
                    tal  = n - (ras[t] + DLY);
                    chk(meas == bel + DLY + tal && bel >= 1 && bel <= NT && tal >= 1 && tal <= NT,
                        "R8 latency sum", meas, bel + DLY + tal);
                    ph = int'(acc[t] % NT);
                    if (lat_tab[t][ph] < 0) lat_tab[t][ph] = meas;
                    else chk(meas == lat_tab[t][ph], "R10 latency isolation", meas, lat_tab[t][ph]);
                end
                if (busy[t] && n == rr[t]) busy[t] = 1'b0;
            end

            // stimulus for this cycle
            dram_rdata = dfun(n);
            for (int t = 0; t < NT; t++) begin
                bit v;
                logic [AW-1:0] a;
                if (i < 250)      v = ((n * 7 + t * 5) % 13) == 0;
                else if (i < 450) v = 1'b1;
                else if (i < 650) v = (t == 1);
                else if (i < 850) v = (t == 0 || t == 2) && ((n + t * 3) % 9) == 0;
                else              v = 1'b0;
                a = afun(n, t);
                req_valid[t] = v;
                req_addr[t*AW +: AW] = a;
                if (v && exp_rdy[t]) begin
                    longint k;
                    busy[t] = 1'b1;
                    acc[t]  = n;
                    k       = n + 1 + ((t - int'((n + 1) % NT) + NT) % NT);
                    ras[t]  = k;
                    rr[t]   = k + DLY + 1 + ((t - int'((k + DLY + 1) % NT) + NT) % NT);
                    mrow[t] = a[AW-1:CW];
                    mcol[t] = a[CW-1:0];
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule